// File: doc/BRIEF.md
# Exclusive Lock Tracker for a Bus Target

This block watches the control lines of a parallel shared-bus target and keeps track of an exclusive (locked) hold that one master places on the target. For every transaction it takes the window-hit vector from the target's address decoder, and counts a transaction as a hit on the target only when one of the lock-qualified windows matches. It also records how the active-low lock line behaves across the address phase. From these it decides whether the transaction claims a new lock, continues the current owner's lock, comes from a foreign master, or goes to some other target.

While a lock is in place the block reports it on `locked`. It raises `owner_access` while the lock owner is the one accessing, and it raises `retry_req` for the duration of any foreign transaction that hits the target, so that the target's protocol engine can answer that transaction with a retry. The hold ends only when the bus is seen idle with the lock line released. Data transfer and the rest of the bus sequencing are outside this block.

Top module: `excl_lock_tracker`

## Requirements
- R1: Synchronous reset, active high, drives `locked`, `owner_access` and `retry_req` to 0.
- R2: While unlocked, a transaction that hits none of the lock-qualified windows leaves `locked` and `owner_access` at 0, even when it uses the lock handshake and transfers data.
- R3: While unlocked, a transaction that hits the target with `lock_n` high throughout leaves `locked` and `owner_access` at 0.
- R4: The lock handshake is `lock_n` high on the address-phase clock (first clock with `frame_n` low after a clock with it high) and low on the next clock. When a hitting transaction uses this handshake while unlocked, `locked` rises on the edge that samples `data_ack` high, and `owner_access` rises one clock later.
- R5: A handshake transaction that ends (`frame_n` high) without any `data_ack` does not set `locked`.
- R6: Only windows 0 and 5 of `win_hit` (bit index = window number) qualify for locking; a hit on any other window counts as no hit.
- R7: While locked, a handshake transaction from the owner that hits the target keeps `locked` and `owner_access` at 1, and `retry_req` stays 0.
- R8: While locked, a transaction that hits the target without the handshake (e.g. `lock_n` low throughout) keeps `locked` at 1 and drives `owner_access` to 0 on the edge one clock after the address phase.
- R9: In the case of R8, `retry_req` rises on that same edge and falls on the edge that samples `frame_n` high.
- R10: While locked, a transaction that hits no qualified window keeps `locked` at 1, drives `owner_access` to 0 and leaves `retry_req` at 0.
- R11: An edge that samples `frame_n` and `lock_n` both high clears `locked`, `owner_access` and `retry_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Transaction framing, active low |
| lock_n | input | 1 | Exclusive-access line, active low |
| win_hit | input | NUM_WIN | Per-window address match from the target decoder, valid on the address phase |
| data_ack | input | 1 | High on a clock where a data phase completes |
| locked | output | 1 | Target is held exclusively |
| owner_access | output | 1 | The current or most recent access came from the lock owner |
| retry_req | output | 1 | Ask the target to retry the ongoing foreign transaction |

## Verification
Each transaction the bench drives takes an address clock, a wait clock and a final data clock, and the bench changes its inputs only on falling edges. The classification of a transaction, and with it `owner_access` and `retry_req` for the locked cases, is due on the second rising edge (one register after the address capture). `locked` is due on the edge that samples `data_ack`, and `owner_access` for a fresh claim one edge after that. Release is due on the first edge that sees both lines high. Every check reads the outputs at the falling edge just after the rising edge on which that result is due, so no result is read before the register that produces it has updated.

// File: rtl/lk_pkg.sv
package lk_pkg;
  typedef enum logic [1:0] {
    XK_NONE    = 2'd0,
    XK_CLAIM   = 2'd1,
    XK_OWNER   = 2'd2,
    XK_FOREIGN = 2'd3
  } xact_kind_t;
endpackage

// File: rtl/lk_phase_track.sv
module lk_phase_track #(
  parameter int NUM_WIN = 6,
  parameter logic [NUM_WIN-1:0] LOCK_WIN_MASK = 6'b100001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_n,
  input  logic               lock_n,
  input  logic [NUM_WIN-1:0] win_hit,
  output logic               sec_phase,
  output logic               lock_open_at_addr,
  output logic               target_hit
);
  logic               frame_q;
  logic               addr_phase;
  logic [NUM_WIN-1:0] win_qual;

  // Mask the decoder result down to the windows that take part in locking.
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_qual
    assign win_qual[g] = win_hit[g] & LOCK_WIN_MASK[g];
  end

  assign addr_phase = frame_q && !frame_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q           <= 1'b1;
      sec_phase         <= 1'b0;
      lock_open_at_addr <= 1'b0;
      target_hit        <= 1'b0;
    end else begin
      frame_q   <= frame_n;
      sec_phase <= addr_phase;
      if (addr_phase) begin
        lock_open_at_addr <= lock_n;
        target_hit        <= |win_qual;
      end
    end
  end
endmodule

// File: rtl/lk_owner_fsm.sv
module lk_owner_fsm
  import lk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic lock_n,
  input  logic data_ack,
  input  logic sec_phase,
  input  logic lock_open_at_addr,
  input  logic target_hit,
  output logic locked,
  output logic owner_access,
  output logic retry_req
);
  xact_kind_t kind_q;
  xact_kind_t kind_d;
  logic       handshake;
  logic       release_now;
  logic       claim_now;
  logic       claim_act;
  logic       grant_q;
  logic       take_lock;

  assign handshake   = lock_open_at_addr && !lock_n;
  assign release_now = frame_n && lock_n;
  assign claim_now   = sec_phase && !locked && target_hit && handshake;
  assign claim_act   = claim_now || (kind_q == XK_CLAIM);
  assign take_lock   = !release_now && !locked && claim_act && data_ack;

  always_comb begin
    kind_d = kind_q;
    if (frame_n) begin
      kind_d = XK_NONE;
    end else if (sec_phase) begin
      if (!target_hit)      kind_d = XK_NONE;
      else if (!handshake)  kind_d = locked ? XK_FOREIGN : XK_NONE;
      else                  kind_d = locked ? XK_OWNER : XK_CLAIM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q       <= XK_NONE;
      locked       <= 1'b0;
      owner_access <= 1'b0;
      retry_req    <= 1'b0;
      grant_q      <= 1'b0;
    end else begin
      kind_q  <= kind_d;
      grant_q <= take_lock;
      if (release_now)     locked <= 1'b0;
      else if (take_lock)  locked <= 1'b1;
      if (release_now)
        owner_access <= 1'b0;
      else if (grant_q)
        owner_access <= 1'b1;
      else if (sec_phase && locked)
        owner_access <= target_hit && handshake;
      if (frame_n)
        retry_req <= 1'b0;
      else if (sec_phase && locked && target_hit && !handshake)
        retry_req <= 1'b1;
    end
  end

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    frame_n && lock_n |=> !locked && !owner_access && !retry_req); // R11
  AST_LOCK_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(data_ack)); // R5
  AST_GRANT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) && !(frame_n && lock_n) |=> owner_access); // R4
  AST_RETRY_FOREIGN: assert property (@(posedge clk) disable iff (rst)
    retry_req |-> locked && !owner_access); // R8
  AST_RETRY_DROPS: assert property (@(posedge clk) disable iff (rst)
    retry_req && frame_n |=> !retry_req); // R9
  AST_OWNER_HOLDS: assert property (@(posedge clk) disable iff (rst)
    owner_access |-> locked); // R7
endmodule

// File: rtl/excl_lock_tracker.sv
module excl_lock_tracker #(
  parameter int NUM_WIN = 6,
  parameter logic [NUM_WIN-1:0] LOCK_WIN_MASK = 6'b100001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_n,
  input  logic               lock_n,
  input  logic [NUM_WIN-1:0] win_hit,
  input  logic               data_ack,
  output logic               locked,
  output logic               owner_access,
  output logic               retry_req
);
  logic sec_phase;
  logic lock_open_at_addr;
  logic target_hit;

  lk_phase_track #(
    .NUM_WIN      (NUM_WIN),
    .LOCK_WIN_MASK(LOCK_WIN_MASK)
  ) u_phase (
    .clk              (clk),
    .rst              (rst),
    .frame_n          (frame_n),
    .lock_n           (lock_n),
    .win_hit          (win_hit),
    .sec_phase        (sec_phase),
    .lock_open_at_addr(lock_open_at_addr),
    .target_hit       (target_hit)
  );

  lk_owner_fsm u_fsm (
    .clk              (clk),
    .rst              (rst),
    .frame_n          (frame_n),
    .lock_n           (lock_n),
    .data_ack         (data_ack),
    .sec_phase        (sec_phase),
    .lock_open_at_addr(lock_open_at_addr),
    .target_hit       (target_hit),
    .locked           (locked),
    .owner_access     (owner_access),
    .retry_req        (retry_req)
  );

  AST_UNLOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !locked && !$past(locked) |-> !retry_req); // R3
endmodule

// File: tb/sim_excl_lock_tracker.sv
module sim_excl_lock_tracker;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_n = 1'b1;
  logic       lock_n = 1'b1;
  logic [5:0] win_hit = '0;
  logic       data_ack = 1'b0;
  logic       locked, owner_access, retry_req;
  int         n_chk = 0;
  int         n_bad = 0;
  logic       p2_lk, p2_own, p2_rty, p3_lk, p3_own, p3_rty, p4_lk, p4_own;

  always #10 clk = ~clk;

  excl_lock_tracker u0 (
    .clk(clk), .rst(rst), .frame_n(frame_n), .lock_n(lock_n),
    .win_hit(win_hit), .data_ack(data_ack),
    .locked(locked), .owner_access(owner_access), .retry_req(retry_req)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drv(input logic f, input logic l, input logic [5:0] h, input logic d);
    @(negedge clk);
    frame_n = f; lock_n = l; win_hit = h; data_ack = d;
  endtask

  // Address clock, wait clock, last data clock, then two idle clocks.
  task automatic access(input logic [5:0] h, input logic l_addr, input logic l_after,
                        input logic d, input logic l_idle);
    drv(1'b0, l_addr, h, 1'b0);
    drv(1'b0, l_after, '0, 1'b0);
    drv(1'b1, l_after, '0, d);
    p2_lk = locked; p2_own = owner_access; p2_rty = retry_req;
    drv(1'b1, l_idle, '0, 1'b0);
    p3_lk = locked; p3_own = owner_access; p3_rty = retry_req;
    drv(1'b1, l_idle, '0, 1'b0);
    p4_lk = locked; p4_own = owner_access;
  endtask

  task automatic t_reset();
    chk("R1 locked after reset", locked, 1'b0);
    chk("R1 owner_access after reset", owner_access, 1'b0);
    chk("R1 retry_req after reset", retry_req, 1'b0);
  endtask

  task automatic t_nontarget_unlocked();
    access(6'b000000, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R2 no window, locked", p4_lk, 1'b0);
    chk("R2 no window, owner", p4_own, 1'b0);
    access(6'b000100, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6 window 2 handshake, locked", p3_lk, 1'b0);
    chk("R6 window 2 handshake, owner", p4_own, 1'b0);
  endtask

  task automatic t_hit_no_lock();
    access(6'b000001, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R3 plain hit, locked", p4_lk, 1'b0);
    chk("R3 plain hit, owner", p4_own, 1'b0);
  endtask

  task automatic t_claim_no_data();
    access(6'b100000, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R5 no data, locked", p3_lk, 1'b0);
    chk("R5 no data, locked later", p4_lk, 1'b0);
  endtask

  task automatic t_claim();
    access(6'b000001, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R4 locked not before data", p2_lk, 1'b0);
    chk("R4 locked on data edge", p3_lk, 1'b1);
    chk("R4 owner not yet", p3_own, 1'b0);
    chk("R4 owner one clock later", p4_own, 1'b1);
  endtask

  task automatic t_owner_cont();
    access(6'b100000, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R7 owner during access", p2_own, 1'b1);
    chk("R7 locked during access", p2_lk, 1'b1);
    chk("R7 no retry", p2_rty, 1'b0);
    chk("R7 locked after", p4_lk, 1'b1);
    chk("R7 owner after", p4_own, 1'b1);
  endtask

  task automatic t_foreign();
    access(6'b000001, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 locked kept", p2_lk, 1'b1);
    chk("R8 owner dropped", p2_own, 1'b0);
    chk("R9 retry raised", p2_rty, 1'b1);
    chk("R9 retry cleared at end", p3_rty, 1'b0);
    chk("R8 locked after", p4_lk, 1'b1);
  endtask

  task automatic t_nontarget_locked();
    access(6'b000001, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R7 owner back", p4_own, 1'b1);
    access(6'b000010, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R10 locked kept", p2_lk, 1'b1);
    chk("R10 owner dropped", p2_own, 1'b0);
    chk("R10 no retry", p2_rty, 1'b0);
    chk("R10 locked after", p4_lk, 1'b1);
  endtask

  task automatic t_release();
    access(6'b000001, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R7 owner before release", p4_own, 1'b1);
    drv(1'b1, 1'b1, '0, 1'b0);
    drv(1'b1, 1'b1, '0, 1'b0);
    chk("R11 locked released", locked, 1'b0);
    chk("R11 owner released", owner_access, 1'b0);
    chk("R11 retry released", retry_req, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nontarget_unlocked();
    t_hit_no_lock();
    t_claim_no_data();
    t_claim();
    t_owner_cont();
    t_foreign();
    t_nontarget_locked();
    t_release();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule